// File: doc/BRIEF.md
# ALU Status Flag Generator

This block turns the operands, result and carry-out of a 16-bit ALU operation into arithmetic status flags. It stores them in a flags register together with three control flags. The status flags are sign, zero, parity, carry, auxiliary carry and overflow. The control flags are single-step trap, interrupt enable and string direction. The ALU supplies both operands, the result, its carry-out (or borrow, for subtraction), an operation class and a byte/word size select. The block registers the new status flags on the clock edge where `update_i` is high.

The control flags never follow ALU results. They change only through per-flag set and clear strobes, and these strobes work independently of the status update. All flags come out as one packed word. Each value appears on the port one clock after the edge that captures it.

Top module: `flag_gen`

## Requirements
- R1: While `rst_ni` is low, every bit of `flags_o` is 0.
- R2: `flags_o` bit 4 (sign) takes the result's most significant bit, which is bit 15 in word mode (`byte_i`=0) and bit 7 in byte mode (`byte_i`=1).
- R3: `flags_o` bit 3 (zero) is set when the result is all zeros, over 16 bits in word mode and over bits 7..0 in byte mode.
- R4: `flags_o` bit 1 (parity) is set when result bits 7..0 hold an even number of ones, in both size modes.
- R5: `flags_o` bit 0 (carry) copies `carry_i` for add (`op_i`=0) and subtract (`op_i`=1), where the input means borrow on subtract. A logic operation (`op_i`=2) clears it.
- R6: `flags_o` bit 2 (auxiliary carry) is the carry or borrow from bit 3 into bit 4, given by a[4]^b[4]^result[4] for add and subtract. A logic operation clears it.
- R7: `flags_o` bit 8 (overflow) is set on add when both operands share a sign and the result's sign differs. It is set on subtract (result = a - b) when the operand signs differ and the result's sign differs from a. Sign bits are taken at bit 15 or bit 7 by size. A logic operation clears it.
- R8: Status bits 8, 4, 3, 2, 1 and 0 keep their value when `update_i` is 0 or when `op_i` is the reserved code 3.
- R9: Control bits, namely trap at bit 5 (index 0 of `ctl_set_i`/`ctl_clr_i`), interrupt enable at bit 6 (index 1) and direction at bit 7 (index 2), are set by their set strobe and cleared by their clear strobe. Clear wins when both are high. Otherwise they hold, whatever happens with `update_i` and `op_i`.
- R10: Every flag change becomes visible on `flags_o` one clock edge after the inputs that cause it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opnd_a_i | input | 16 | First ALU operand |
| opnd_b_i | input | 16 | Second ALU operand |
| result_i | input | 16 | ALU result |
| carry_i | input | 1 | ALU carry-out, or borrow on subtract |
| op_i | input | 2 | Operation class: 0 add, 1 subtract, 2 logic, 3 reserved |
| byte_i | input | 1 | 1 selects byte-size flag rules |
| update_i | input | 1 | Capture status flags this cycle |
| ctl_set_i | input | 3 | Set strobes for trap, interrupt, direction |
| ctl_clr_i | input | 3 | Clear strobes for trap, interrupt, direction |
| flags_o | output | 9 | Packed flags register |

## Verification
A status update and a control-flag strobe can arrive in the same cycle, and both write the same packed register. The bench provokes this by driving a logic or arithmetic update together with set and clear strobes, including a set and a clear on one flag at once. It then checks the full word one edge later. Every status bit must match the ALU rules, and every control bit must match the strobe outcome with clear winning. No bit may be disturbed by the other path.

// File: rtl/flag_gen_pkg.sv
package flag_gen_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CTL_N  = 3;

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_LOGIC = 2'd2,
    OP_RSVD  = 2'd3
  } op_cls_e;

  typedef struct packed {
    logic ovf;
    logic sign;
    logic zero;
    logic aux;
    logic par;
    logic cy;
  } status_t;
endpackage

// File: rtl/flag_arith.sv
module flag_arith
  import flag_gen_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] r_i,
  input  logic         cy_i,
  input  op_cls_e      op_i,
  input  logic         byte_i,
  output status_t      st_o
);
  localparam int unsigned BW  = 8;
  localparam int unsigned NIB = 4;

  logic a_msb, b_msb, r_msb;
  logic zero_w, zero_b, ovf_add, ovf_sub, arith;

  always_comb begin
    a_msb  = byte_i ? a_i[BW-1] : a_i[W-1];
    b_msb  = byte_i ? b_i[BW-1] : b_i[W-1];
    r_msb  = byte_i ? r_i[BW-1] : r_i[W-1];
    zero_w = (r_i == '0);
    zero_b = (r_i[BW-1:0] == '0);
    ovf_add = (a_msb == b_msb) && (r_msb != a_msb);
    ovf_sub = (a_msb != b_msb) && (r_msb != a_msb);
    arith   = (op_i == OP_ADD) || (op_i == OP_SUB);

    st_o.sign = r_msb;
    st_o.zero = byte_i ? zero_b : zero_w;
    st_o.par  = ~^r_i[BW-1:0];
    st_o.cy   = arith & cy_i;
    // carry/borrow into bit 4 leaves its trace in the bit-4 sum
    st_o.aux  = arith & (a_i[NIB] ^ b_i[NIB] ^ r_i[NIB]);
    st_o.ovf  = (op_i == OP_ADD) ? ovf_add :
                (op_i == OP_SUB) ? ovf_sub : 1'b0;
  end
endmodule

// File: rtl/flag_ctl_bank.sv
module flag_ctl_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (clr_i[g]) q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;
    end

    AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[g] |=> !q_o[g]);  // R9
    AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] && !clr_i[g] |=> q_o[g]);  // R9
    AST_CTL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !set_i[g] && !clr_i[g] |=> $stable(q_o[g]));  // R9
  end
endmodule

// File: rtl/flag_gen.sv
module flag_gen
  import flag_gen_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] opnd_a_i,
  input  logic [15:0] opnd_b_i,
  input  logic [15:0] result_i,
  input  logic        carry_i,
  input  logic [1:0]  op_i,
  input  logic        byte_i,
  input  logic        update_i,
  input  logic [2:0]  ctl_set_i,
  input  logic [2:0]  ctl_clr_i,
  output logic [8:0]  flags_o
);
  op_cls_e      op_cls;
  status_t      st_next, st_q;
  logic [CTL_N-1:0] ctl_q;
  logic         st_we;

  assign op_cls = op_cls_e'(op_i);
  assign st_we  = update_i && (op_cls != OP_RSVD);

  flag_arith #(.W(DATA_W)) u_arith (
    .a_i   (opnd_a_i),
    .b_i   (opnd_b_i),
    .r_i   (result_i),
    .cy_i  (carry_i),
    .op_i  (op_cls),
    .byte_i(byte_i),
    .st_o  (st_next)
  );

  flag_ctl_bank #(.N(CTL_N)) u_ctl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ctl_set_i),
    .clr_i (ctl_clr_i),
    .q_o   (ctl_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= '0;
    else if (st_we) st_q <= st_next;
  end

  // packed layout: ovf | dir intr trap | sign zero aux par cy
  assign flags_o = {st_q.ovf, ctl_q, st_q.sign, st_q.zero, st_q.aux, st_q.par, st_q.cy};

  AST_LOGIC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && op_i == 2'd2 |=> !flags_o[0] && !flags_o[2] && !flags_o[8]);  // R5
  AST_CARRY_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && op_i[1] == 1'b0 |=> flags_o[0] == $past(carry_i));  // R5
  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i || op_i == 2'd3 |=> $stable({flags_o[8], flags_o[4:0]}));  // R8
  AST_ZERO_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && op_i != 2'd3 && !byte_i && result_i == 16'h0 |=> flags_o[3]);  // R3
  AST_SIGN_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && op_i != 2'd3 && !byte_i |=> flags_o[4] == $past(result_i[15]));  // R2
endmodule

// File: tb/flag_gen_tb_top.sv
`timescale 1ns/1ps
module flag_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0, r = '0;
  logic        cy = 1'b0, byte_sel = 1'b0, upd = 1'b0;
  logic [1:0]  op = '0;
  logic [2:0]  cset = '0, cclr = '0;
  logic [8:0]  flags;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flag_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .opnd_a_i(a), .opnd_b_i(b), .result_i(r),
    .carry_i(cy), .op_i(op), .byte_i(byte_sel), .update_i(upd),
    .ctl_set_i(cset), .ctl_clr_i(cclr), .flags_o(flags)
  );

  // {a, b, result, carry, op, byte, expected flags}
  localparam logic [60:0] VECS [10] = '{
    {16'h0001, 16'h0001, 16'h0002, 1'b0, 2'd0, 1'b0, 9'h000},  // plain add
    {16'h7FFF, 16'h0001, 16'h8000, 1'b0, 2'd0, 1'b0, 9'h116},  // R7 add ovf, R2 sign
    {16'hFFFF, 16'h0001, 16'h0000, 1'b1, 2'd0, 1'b0, 9'h00F},  // R3 zero, R5 carry
    {16'h0000, 16'h0001, 16'hFFFF, 1'b1, 2'd1, 1'b0, 9'h017},  // R5 borrow, R4 parity
    {16'h8000, 16'h0001, 16'h7FFF, 1'b0, 2'd1, 1'b0, 9'h106},  // R7 sub ovf, R6 aux
    {16'h127F, 16'h0001, 16'h1280, 1'b0, 2'd0, 1'b1, 9'h114},  // R2 byte sign
    {16'h3405, 16'h1205, 16'h2200, 1'b0, 2'd1, 1'b1, 9'h00A},  // R3 byte zero
    {16'hF0F0, 16'hFF00, 16'hF000, 1'b1, 2'd2, 1'b0, 9'h012},  // R5 R6 R7 logic clears
    {16'h00FF, 16'h0080, 16'h0080, 1'b1, 2'd2, 1'b1, 9'h010},  // logic byte
    {16'h00FF, 16'h0001, 16'h0100, 1'b1, 2'd0, 1'b1, 9'h00F}   // byte carry + zero
  };

  task automatic check(input string tag, input logic [8:0] exp);
    n_chk++;
    if (flags !== exp) begin
      n_fail++;
      $display("FAIL %s: flags=%h expected=%h", tag, flags, exp);
    end
  endtask

  task automatic step(input logic [15:0] ta, tb, tr, input logic tc,
                      input logic [1:0] top, input logic tbyte, tupd,
                      input logic [2:0] ts, tcl);
    @(negedge clk);
    a = ta; b = tb; r = tr; cy = tc; op = top; byte_sel = tbyte;
    upd = tupd; cset = ts; cclr = tcl;
    @(negedge clk);  // R10: result registered at the edge in between
    upd = 1'b0; cset = '0; cclr = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1;
    check("R1 reset", 9'h000);
    repeat (2) @(negedge clk);
    check("R1 reset held", 9'h000);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      step(VECS[i][60:45], VECS[i][44:29], VECS[i][28:13], VECS[i][12],
           VECS[i][11:10], VECS[i][9], 1'b1, 3'b000, 3'b000);
      check($sformatf("table vec %0d R2 R3 R4 R5 R6 R7 R10", i), VECS[i][8:0]);
    end

    // R8: no update keeps last status (9'h00F)
    step(16'h7FFF, 16'h0001, 16'h8000, 1'b0, 2'd0, 1'b0, 1'b0, 3'b000, 3'b000);
    check("R8 update low", 9'h00F);
    step(16'h7FFF, 16'h0001, 16'h8000, 1'b0, 2'd3, 1'b0, 1'b1, 3'b000, 3'b000);
    check("R8 reserved op", 9'h00F);

    // R9: strobes
    step('0, '0, '0, 1'b0, 2'd0, 1'b0, 1'b0, 3'b001, 3'b000);
    check("R9 set trap", 9'h02F);
    step('0, '0, '0, 1'b0, 2'd0, 1'b0, 1'b0, 3'b110, 3'b000);
    check("R9 set intr dir", 9'h0EF);
    step('0, '0, '0, 1'b0, 2'd0, 1'b0, 1'b0, 3'b000, 3'b000);
    check("R9 hold", 9'h0EF);
    // same-cycle: logic update plus set/clear collision on trap, clear of dir
    step(16'hF0F0, 16'hFF00, 16'hF000, 1'b1, 2'd2, 1'b0, 1'b1, 3'b001, 3'b101);
    check("R9 clear wins with update", 9'h052);
    // same-cycle: add update with overflow plus set of dir
    step(16'h7FFF, 16'h0001, 16'h8000, 1'b0, 2'd0, 1'b0, 1'b1, 3'b100, 3'b000);
    check("R9 R7 set with update", 9'h1D6);
    step('0, '0, '0, 1'b0, 2'd0, 1'b0, 1'b0, 3'b000, 3'b010);
    check("R9 clear intr", 9'h196);

    // R1: asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1 check("R1 async reset", 9'h000);
    @(negedge clk);
    rst_n = 1'b1;
    finish_run();
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: expired");
      finish_run();
    end
  end
endmodule